// File: doc/BRIEF.md
# MSI Coherence Controller for One Cache Line

This block follows the coherence state of a single line in a private cache that sits on a shared snooping bus. The three states are Invalid, Shared and Modified. Local requests from the core (load, store, evict) and transactions snooped from other caches (read, read-for-ownership, invalidate) both move the line between these states. When a local request cannot finish on its own, the block issues a bus action: a plain read, a read-for-ownership, an upgrade invalidate or a write-back. When the line is the owner and must give its data to another cache, the block raises a one-cycle supply strobe.

The core sends a request as a single-cycle pulse, and the block holds that request internally until it is finished. If the request needs the bus, the block raises a bus request and keeps it high until grant. The grant cycle completes the transaction. The line state changes only at that point, and a one-cycle done pulse follows. Snoops always take precedence over a waiting local request. The local request is then evaluated again against the state the snoop left behind.

Top module: `msiLineCtrl`

## Requirements
- R1: During and right after reset, the line is Invalid (lineState 0), and busReq, coreDone and supplyData are all low. State codes are: 0 Invalid, 1 Shared, 2 Modified.
- R2: From Invalid, the following happens. A load (coreOp 0) requests the bus with busCmd 1 (read) and ends in Shared. A store (coreOp 1) requests the bus with busCmd 2 (read-for-ownership) and ends in Modified. An evict (coreOp 2) finishes with no bus request.
- R3: From Shared, a load finishes with no bus request. A store requests the bus with busCmd 3 (upgrade invalidate) and ends in Modified. An evict ends in Invalid with no bus request.
- R4: From Modified, loads and stores finish with no bus request. An evict requests the bus with busCmd 4 (write-back) and ends in Invalid.
- R5: In Shared, a snooped read (snoopCmd 0) leaves the line Shared and does not raise supplyData. A snooped read-for-ownership (snoopCmd 1) or invalidate (snoopCmd 2) moves the line to Invalid.
- R6: In Modified, a snooped read raises supplyData and moves the line to Shared. A snooped read-for-ownership raises supplyData and moves the line to Invalid. A snooped invalidate moves the line to Invalid without supply. In Invalid, snoops have no effect.
- R7: A bus request stays high with a steady busCmd and an unchanged state until busGrant. The state update happens at the grant edge, and coreDone is high in the following cycle. busCmd is 0 whenever busReq is low.
- R8: In a cycle with snoopValid high, busReq is low and busGrant is ignored. The snoop is applied first, and the pending request is then re-evaluated against the new state. For example, a store from Shared that is hit by a snooped read-for-ownership then requests busCmd 2.
- R9: coreDone and supplyData are single-cycle pulses. Each accepted request produces exactly one coreDone. A request that needs no bus finishes two clock edges after its pulse, provided no snoop intervenes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| coreReq | input | 1 | One-cycle pulse that starts a local request |
| coreOp | input | 2 | Local operation: 0 load, 1 store, 2 evict |
| coreDone | output | 1 | One-cycle pulse that marks a finished local request |
| snoopValid | input | 1 | A transaction from another cache is on the bus |
| snoopCmd | input | 2 | Snooped kind: 0 read, 1 read-for-ownership, 2 invalidate |
| supplyData | output | 1 | One-cycle strobe: this line provides the data |
| busReq | output | 1 | Request for the bus |
| busGrant | input | 1 | Bus granted; completes the requested transaction |
| busCmd | output | 3 | Bus action: 0 none, 1 read, 2 read-for-ownership, 3 invalidate, 4 write-back |
| lineState | output | 2 | Current coherence state |

## Verification
The key collision is a snoop arriving in the same cycle that a waiting local request could complete, possibly with busGrant also high. A directed case sets up an upgrade from Shared and then sends a snooped read-for-ownership together with a grant. The random phase places snoops and grants at random around pending requests. Every cycle, a reference model derived from the requirements predicts the expected busReq, busCmd, state and pulses. The checks confirm that the grant was ignored, that the state follows the snoop, and that the request that follows carries the re-evaluated command.

// File: rtl/msiPkg.sv
package msiPkg;
  localparam int ST_W  = 2;
  localparam int OP_W  = 2;
  localparam int SNP_W = 2;
  localparam int CMD_W = 3;

  typedef enum logic [ST_W-1:0]  {ST_I, ST_S, ST_M} lineSt_e;
  typedef enum logic [OP_W-1:0]  {OP_LOAD, OP_STORE, OP_EVICT} coreOp_e;
  typedef enum logic [SNP_W-1:0] {SNP_RD, SNP_RDX, SNP_INV} snoopCmd_e;
  typedef enum logic [CMD_W-1:0] {BUS_NONE, BUS_RD, BUS_RDX, BUS_INV, BUS_WB} busCmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    loadState;
    lineSt_e nextState;
    logic    retire;
    logic    supply;
  } ctrlStb_t;
endpackage

// File: rtl/msiDatapath.sv
module msiDatapath import msiPkg::*; (
  input  logic            clk,
  input  logic            rstN,
  input  logic            coreReq,
  input  logic [OP_W-1:0] coreOp,
  input  ctrlStb_t        stb,
  output lineSt_e         lineState,
  output logic            pendValid,
  output coreOp_e         pendOp,
  output logic            coreDone,
  output logic            supplyData
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineState  <= ST_I;
      pendValid  <= 1'b0;
      pendOp     <= OP_LOAD;
      coreDone   <= 1'b0;
      supplyData <= 1'b0;
    end else begin
      if (stb.loadState) lineState <= stb.nextState;
      coreDone   <= stb.retire;
      supplyData <= stb.supply;
      if (stb.retire) begin
        pendValid <= 1'b0;
      end else if (coreReq && !pendValid) begin
        pendValid <= 1'b1;
        pendOp    <= coreOp_e'(coreOp);
      end
    end
  end

  // R9: completion is a single-cycle pulse
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    coreDone |=> !coreDone);
  // R9: supply strobe is a single-cycle pulse
  assert_supply_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    supplyData |=> !supplyData);
  // R6: only an owner supplies data
  assert_supply_owner_R6: assert property (@(posedge clk) disable iff (!rstN)
    supplyData |-> ($past(lineState) == ST_M));
endmodule

// File: rtl/msiControl.sv
module msiControl import msiPkg::*; (
  input  logic             clk,
  input  logic             rstN,
  input  lineSt_e          lineState,
  input  logic             pendValid,
  input  coreOp_e          pendOp,
  input  logic             snoopValid,
  input  logic [SNP_W-1:0] snoopCmd,
  input  logic             busGrant,
  output ctrlStb_t         stb,
  output logic             busReq,
  output busCmd_e          busCmd
);
  function automatic busCmd_e localCmd(lineSt_e s, coreOp_e o);
    busCmd_e c;
    c = BUS_NONE;
    case (s)
      ST_I: begin
        case (o)
          OP_STORE: c = BUS_RDX;
          OP_EVICT: c = BUS_NONE;
          default:  c = BUS_RD;
        endcase
      end
      ST_S: c = (o == OP_STORE) ? BUS_INV : BUS_NONE;
      ST_M: c = (o == OP_EVICT) ? BUS_WB : BUS_NONE;
      default: c = BUS_NONE;
    endcase
    return c;
  endfunction

  function automatic lineSt_e localNext(lineSt_e s, coreOp_e o);
    lineSt_e n;
    case (o)
      OP_EVICT: n = ST_I;
      OP_STORE: n = ST_M;
      default:  n = (s == ST_I) ? ST_S : s;
    endcase
    return n;
  endfunction

  function automatic lineSt_e snoopNext(lineSt_e s, snoopCmd_e c);
    lineSt_e n;
    if (s == ST_I)        n = ST_I;
    else if (c == SNP_RD) n = ST_S;
    else                  n = ST_I;
    return n;
  endfunction

  snoopCmd_e snp;
  busCmd_e   needCmd;

  always_comb begin
    snp           = snoopCmd_e'(snoopCmd);
    needCmd       = localCmd(lineState, pendOp);
    stb           = '0;
    stb.nextState = lineState;
    busReq        = 1'b0;
    busCmd        = BUS_NONE;
    if (snoopValid) begin
      stb.loadState = 1'b1;
      stb.nextState = snoopNext(lineState, snp);
      stb.supply    = (lineState == ST_M) && (snp != SNP_INV);
    end else if (pendValid) begin
      busReq = (needCmd != BUS_NONE);
      busCmd = needCmd;
      if ((needCmd == BUS_NONE) || busGrant) begin
        stb.loadState = 1'b1;
        stb.nextState = localNext(lineState, pendOp);
        stb.retire    = 1'b1;
      end
    end
  end

  // R8: no bus request without a pending request or during a snoop
  assert_req_gated_R8: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> (pendValid && !snoopValid));
  // R7: state holds while waiting for grant
  assert_wait_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busGrant) |=> $stable(lineState));
  // R3: a granted upgrade lands in Modified
  assert_upgrade_lands_m_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busGrant && busCmd == BUS_INV) |=> (lineState == ST_M));
  // R4: a granted write-back empties the line
  assert_wb_empties_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busGrant && busCmd == BUS_WB) |=> (lineState == ST_I));
  // R5: a sharer loses the line on an exclusive snoop
  assert_sharer_drops_R5: assert property (@(posedge clk) disable iff (!rstN)
    (snoopValid && lineState == ST_S && snoopCmd != 2'd0) |=> (lineState == ST_I));
endmodule

// File: rtl/msiLineCtrl.sv
module msiLineCtrl import msiPkg::*; (
  input  logic             clk,
  input  logic             rstN,
  input  logic             coreReq,
  input  logic [OP_W-1:0]  coreOp,
  output logic             coreDone,
  input  logic             snoopValid,
  input  logic [SNP_W-1:0] snoopCmd,
  output logic             supplyData,
  output logic             busReq,
  input  logic             busGrant,
  output logic [CMD_W-1:0] busCmd,
  output logic [ST_W-1:0]  lineState
);
  ctrlStb_t stb;
  lineSt_e  stateQ;
  logic     pendValid;
  coreOp_e  pendOp;
  busCmd_e  cmdE;

  msiControl uCtrl (
    .clk(clk), .rstN(rstN), .lineState(stateQ), .pendValid(pendValid),
    .pendOp(pendOp), .snoopValid(snoopValid), .snoopCmd(snoopCmd),
    .busGrant(busGrant), .stb(stb), .busReq(busReq), .busCmd(cmdE)
  );

  msiDatapath uDp (
    .clk(clk), .rstN(rstN), .coreReq(coreReq), .coreOp(coreOp), .stb(stb),
    .lineState(stateQ), .pendValid(pendValid), .pendOp(pendOp),
    .coreDone(coreDone), .supplyData(supplyData)
  );

  assign busCmd    = cmdE;
  assign lineState = stateQ;
endmodule

// File: tb/tb_msiLineCtrl.sv
module tb_msiLineCtrl;
  logic clk = 1'b0;
  logic rstN;
  logic coreReq, snoopValid, busGrant;
  logic [1:0] coreOp, snoopCmd;
  logic coreDone, supplyData, busReq;
  logic [2:0] busCmd;
  logic [1:0] lineState;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  int mState = 0;
  bit mPend = 0;
  int mOp = 0;
  bit mDone = 0;
  bit mSup = 0;

  always #10 clk = ~clk;

  msiLineCtrl dut (
    .clk(clk), .rstN(rstN), .coreReq(coreReq), .coreOp(coreOp), .coreDone(coreDone),
    .snoopValid(snoopValid), .snoopCmd(snoopCmd), .supplyData(supplyData),
    .busReq(busReq), .busGrant(busGrant), .busCmd(busCmd), .lineState(lineState)
  );

  function automatic int cmdFor(int s, int o);
    if (s == 0) return (o == 1) ? 2 : ((o == 2) ? 0 : 1);
    if (s == 1) return (o == 1) ? 3 : 0;
    return (o == 2) ? 4 : 0;
  endfunction

  function automatic int nextLocal(int s, int o);
    if (o == 2) return 0;
    if (o == 1) return 2;
    return (s == 0) ? 1 : s;
  endfunction

  function automatic int nextSnoop(int s, int c);
    if (s == 0) return 0;
    return (c == 0) ? 1 : 0;
  endfunction

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check combinational outputs, then registered ones
  task automatic step(input bit req, input int op, input bit snp, input int scmd, input bit gnt, input string tag);
    bit expReq;
    int expCmd, nState, nOp;
    bit nPend, nDone, nSup;
    coreReq = req; coreOp = op[1:0]; snoopValid = snp; snoopCmd = scmd[1:0]; busGrant = gnt;
    #1;
    expReq = mPend && !snp && (cmdFor(mState, mOp) != 0);
    expCmd = expReq ? cmdFor(mState, mOp) : 0;
    chk(tag, "busReq", 8'(busReq), 8'(expReq));
    chk(tag, "busCmd", 8'(busCmd), 8'(expCmd));
    nState = mState; nPend = mPend; nOp = mOp; nDone = 0; nSup = 0;
    if (snp) begin
      nSup = (mState == 2) && (scmd != 2);
      nState = nextSnoop(mState, scmd);
    end else if (mPend && (cmdFor(mState, mOp) == 0 || gnt)) begin
      nState = nextLocal(mState, mOp);
      nPend = 0; nDone = 1;
    end
    if (req && !mPend) begin nPend = 1; nOp = op; end
    @(negedge clk);
    mState = nState; mPend = nPend; mOp = nOp; mDone = nDone; mSup = nSup;
    chk(tag, "lineState", 8'(lineState), 8'(mState));
    chk(tag, "coreDone", 8'(coreDone), 8'(mDone));
    chk(tag, "supplyData", 8'(supplyData), 8'(mSup));
  endtask

  task automatic runOp(input int op, input string tag);
    step(1, op, 0, 0, 0, tag);
    for (int k = 0; k < 8 && mPend; k++) step(0, 0, 0, 0, (k > 0), tag);
  endtask

  task automatic snoop(input int c, input string tag);
    step(0, 0, 1, c, 0, tag);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 0; coreReq = 0; coreOp = 0; snoopValid = 0; snoopCmd = 0; busGrant = 0;
    repeat (3) @(negedge clk);
    chk("R1", "lineState", 8'(lineState), 8'd0);
    chk("R1", "busReq", 8'(busReq), 8'd0);
    chk("R1", "coreDone", 8'(coreDone), 8'd0);
    chk("R1", "supplyData", 8'(supplyData), 8'd0);
    rstN = 1;
    @(negedge clk);
    chk("R1", "lineState after release", 8'(lineState), 8'd0);

    runOp(2, "R2");            // evict from I, no bus
    runOp(0, "R2");            // load I -> S (waits one cycle, R7)
    runOp(0, "R3");            // load in S
    runOp(2, "R3");            // evict S -> I
    runOp(1, "R2");            // store I -> M
    runOp(0, "R4");            // load in M
    runOp(1, "R4");            // store in M
    snoop(0, "R6");            // M read snoop -> S with supply
    snoop(0, "R5");            // S read snoop stays S
    snoop(1, "R5");            // S rdx -> I
    snoop(0, "R6");            // I no effect
    snoop(2, "R6");
    runOp(0, "R5");
    snoop(2, "R5");            // S inv -> I
    runOp(1, "R6");
    snoop(1, "R6");            // M rdx -> I with supply
    runOp(1, "R6");
    snoop(2, "R6");            // M inv -> I no supply
    runOp(1, "R4");
    runOp(2, "R4");            // M writeback -> I

    // R7: hold request several cycles without grant
    runOp(0, "R7");
    step(1, 1, 0, 0, 0, "R7");
    for (int k = 0; k < 4; k++) step(0, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 1, "R7");
    step(0, 0, 0, 0, 0, "R9");

    // R8: upgrade pending, snooped rdx with grant in same cycle
    runOp(2, "R8");
    runOp(0, "R8");            // now Shared
    step(1, 1, 0, 0, 0, "R8");
    step(0, 0, 1, 1, 1, "R8"); // grant ignored, line invalidated
    step(0, 0, 0, 0, 0, "R8"); // request now rdx
    step(0, 0, 0, 0, 1, "R8");
    step(0, 0, 0, 0, 0, "R8");

    for (int i = 0; i < 4000; i++) begin
      bit req, snp, gnt;
      int op, sc;
      req = !mPend && ($urandom % 3 == 0);
      op  = $urandom % 3;
      snp = ($urandom % 4 == 0);
      sc  = $urandom % 3;
      gnt = ($urandom % 2 == 0);
      step(req, op, snp, sc, gnt, "R9");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule